// File: doc/BRIEF.md
# Packet Bus Transmit Port (PHY side)

This block sits on the PHY side of a 16-bit, multi-port packet transmit bus. A link device picks a port by putting a 5-bit address on the bus while the active-low write enable is high. It then pulls the enable low and streams words to that port. Each word carries a start marker, an end marker, a byte-count modulo bit, an error marker and a parity bit. The block turns every accepted word into a one-cycle write strobe toward one of several per-port FIFOs. Each FIFO reports back only its current word count.

On every accepted word the block checks parity, with even or odd sense chosen by an input. It also checks the framing markers. Any mismatch raises a single-cycle flag, and the word is passed on unchanged. The only exception is the lower byte of a one-byte final word, which is cleared. The block also drives a packet-available status for the port chosen in the selection phase. That status has its own output enable, which models a tri-state driver: it is released while the enable is high and whenever the selection was the null address or an address outside this device's range.

Top module: `pktbus_tx_port`

## Requirements
- R1: During and after reset, with the enable held high, `wr_strobe`, `par_err`, `proto_err`, `avail` and `avail_oe` are all 0.
- R2: The port is taken from `addr` in each cycle where `wr_en_n` is 1. While `wr_en_n` stays 0, address changes have no effect: every word goes to the port latched on the last cycle before the enable fell.
- R3: Address 5'h1F selects no port, and neither does any address outside BASE_ADDR .. BASE_ADDR+NPORTS-1. After such a selection, enabled cycles raise no `wr_strobe` bit, no flag, and no `avail_oe`.
- R4: Each cycle with `wr_en_n`=0 and a valid selection gives, one cycle later, a one-hot `wr_strobe` with bit (port) set, where port = addr-BASE_ADDR. The same cycle carries the word's data and markers on `wr_data`, `wr_sop`, `wr_eop`, `wr_mod`, `wr_err`.
- R5: Parity covers all data bits. The word is bad when XOR(data) XOR `par_in` differs from `par_odd` (0 = even, 1 = odd). A bad word pulses `par_err` in its strobe cycle, and `wr_data` still equals the input data.
- R6: When `eop`=1 and `mod_in`=1, `wr_data` carries the upper byte with the lower byte forced to 0. In every other case the data passes unchanged.
- R7: A word with `sop` and `eop` both 1 pulses `proto_err` in its strobe cycle.
- R8: A word with `err_in`=1 and `eop`=0 pulses `proto_err`.
- R9: A word with `mod_in`=1 and `eop`=0 pulses `proto_err`, and its data is stored unchanged.
- R10: While `wr_en_n`=0 with a valid selection, `avail_oe`=1 and `avail` is 1 exactly when the selected port's count is below THRESH. Both follow the count in the same cycle.
- R11: In every cycle where `wr_en_n`=1, `avail_oe` and `avail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_n | input | 1 | Active-low write enable; high = selection phase |
| addr | input | 5 | Port address; 5'h1F is null |
| data | input | 16 | Word data, upper byte first |
| par_in | input | 1 | Parity bit over `data` |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| sop | input | 1 | First word of packet |
| eop | input | 1 | Last word of packet |
| mod_in | input | 1 | On last word: only upper byte valid |
| err_in | input | 1 | Packet error marker |
| fifo_count | input | NPORTS*CW | Word counts of the port FIFOs, port 0 in the low bits |
| wr_strobe | output | NPORTS | One-hot FIFO write strobe |
| wr_data | output | 16 | Word to write |
| wr_sop | output | 1 | Start marker of written word |
| wr_eop | output | 1 | End marker of written word |
| wr_mod | output | 1 | Modulo bit of written word |
| wr_err | output | 1 | Error marker of written word |
| avail | output | 1 | Selected port below fill threshold |
| avail_oe | output | 1 | Drive enable for `avail` |
| par_err | output | 1 | Parity error pulse |
| proto_err | output | 1 | Framing violation pulse |

## Verification
A parity failure and a framing violation can be reported for the same word in the same cycle. The marker sweep provokes this on purpose: it walks all sixteen marker combinations and gives every odd-numbered combination wrong parity. Each flag is then compared on its own against the value the bench works out from its rule, so one flag cannot hide or imitate the other. In the same way, the address sweep and the latching test run a write strobe and a selection change together, since the address moves while the enable is low.

// File: rtl/pktbus_pkg.sv
package pktbus_pkg;
    localparam logic [4:0] NULL_ADDR = 5'h1F;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_sense_e;

    typedef struct packed {
        logic sop;
        logic eop;
        logic mod;
        logic err;
    } mark_t;
endpackage

// File: rtl/pktbus_addr_dec.sv
module pktbus_addr_dec #(
    parameter int AW        = 5,
    parameter int NPORTS    = 4,
    parameter int BASE_ADDR = 0,
    localparam int PW       = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [PW-1:0] idx
);
    import pktbus_pkg::*;

    logic [NPORTS-1:0] match;

    for (genvar p = 0; p < NPORTS; p++) begin : g_match
        localparam logic [AW-1:0] PADDR = AW'(BASE_ADDR + p);
        assign match[p] = (addr == PADDR) && (addr != NULL_ADDR);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (match[p]) idx = PW'(p);
        end
    end
endmodule

// File: rtl/pktbus_word_chk.sv
module pktbus_word_chk #(
    parameter int DW = 16,
    localparam int HB = DW / 2
) (
    input  logic          [DW-1:0] data,
    input  logic                   par_in,
    input  logic                   par_odd,
    input  pktbus_pkg::mark_t      mark,
    output logic          [DW-1:0] data_out,
    output logic                   par_bad,
    output logic                   viol
);
    logic both_ends;
    logic stray_err;
    logic stray_mod;

    always_comb begin
        par_bad   = ((^data) ^ par_in) != par_odd;
        both_ends = mark.sop & mark.eop;
        stray_err = mark.err & ~mark.eop;
        stray_mod = mark.mod & ~mark.eop;
        viol      = both_ends | stray_err | stray_mod;
        data_out  = data;
        if (mark.eop && mark.mod) data_out[HB-1:0] = '0;
    end
endmodule

// File: rtl/pktbus_fill_cmp.sv
module pktbus_fill_cmp #(
    parameter int NPORTS = 4,
    parameter int CW     = 5,
    parameter int THRESH = 12,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [NPORTS*CW-1:0] counts,
    input  logic [PW-1:0]        idx,
    output logic                 below
);
    logic [NPORTS-1:0] under;

    for (genvar p = 0; p < NPORTS; p++) begin : g_cmp
        assign under[p] = int'(counts[p*CW +: CW]) < THRESH;
    end

    always_comb begin
        below = 1'b0;
        for (int p = 0; p < NPORTS; p++) begin
            if (idx == PW'(p)) below = under[p];
        end
    end
endmodule

// File: rtl/pktbus_tx_port.sv
module pktbus_tx_port #(
    parameter int AW         = 5,
    parameter int DW         = 16,
    parameter int NPORTS     = 4,
    parameter int BASE_ADDR  = 0,
    parameter int FIFO_DEPTH = 16,
    parameter int THRESH     = 12,
    localparam int CW        = $clog2(FIFO_DEPTH + 1),
    localparam int PW        = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_n,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        data,
    input  logic                 par_in,
    input  logic                 par_odd,
    input  logic                 sop,
    input  logic                 eop,
    input  logic                 mod_in,
    input  logic                 err_in,
    input  logic [NPORTS*CW-1:0] fifo_count,
    output logic [NPORTS-1:0]    wr_strobe,
    output logic [DW-1:0]        wr_data,
    output logic                 wr_sop,
    output logic                 wr_eop,
    output logic                 wr_mod,
    output logic                 wr_err,
    output logic                 avail,
    output logic                 avail_oe,
    output logic                 par_err,
    output logic                 proto_err
);
    import pktbus_pkg::*;

    typedef struct packed {
        logic              sel_ok;
        logic [PW-1:0]     sel_idx;
        logic [NPORTS-1:0] strobe;
        logic [DW-1:0]     wdata;
        mark_t             wmark;
        logic              perr;
        logic              pviol;
    } state_t;

    state_t st_d, st_q;

    logic          dec_hit;
    logic [PW-1:0] dec_idx;
    logic [DW-1:0] chk_data;
    logic          chk_par;
    logic          chk_viol;
    logic          fill_below;
    mark_t         in_mark;

    assign in_mark = '{sop: sop, eop: eop, mod: mod_in, err: err_in};

    pktbus_addr_dec #(
        .AW(AW), .NPORTS(NPORTS), .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .addr(addr), .hit(dec_hit), .idx(dec_idx)
    );

    pktbus_word_chk #(
        .DW(DW)
    ) u_chk_word (
        .data(data), .par_in(par_in), .par_odd(par_odd), .mark(in_mark),
        .data_out(chk_data), .par_bad(chk_par), .viol(chk_viol)
    );

    pktbus_fill_cmp #(
        .NPORTS(NPORTS), .CW(CW), .THRESH(THRESH)
    ) u_fill (
        .counts(fifo_count), .idx(st_q.sel_idx), .below(fill_below)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = '0;
        st_d.perr   = 1'b0;
        st_d.pviol  = 1'b0;
        if (wr_en_n) begin
            st_d.sel_ok  = dec_hit;
            st_d.sel_idx = dec_idx;
        end else if (st_q.sel_ok) begin
            st_d.strobe[st_q.sel_idx] = 1'b1;
            st_d.wdata = chk_data;
            st_d.wmark = in_mark;
            st_d.perr  = chk_par;
            st_d.pviol = chk_viol;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_strobe = st_q.strobe;
    assign wr_data   = st_q.wdata;
    assign wr_sop    = st_q.wmark.sop;
    assign wr_eop    = st_q.wmark.eop;
    assign wr_mod    = st_q.wmark.mod;
    assign wr_err    = st_q.wmark.err;
    assign par_err   = st_q.perr;
    assign proto_err = st_q.pviol;
    assign avail_oe  = ~wr_en_n & st_q.sel_ok;
    assign avail     = avail_oe & fill_below;
endmodule

// File: rtl/pktbus_tx_port_chk.sv
module pktbus_tx_port_chk #(
    parameter int AW     = 5,
    parameter int DW     = 16,
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_n,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     data,
    input logic              par_in,
    input logic              par_odd,
    input logic              sop,
    input logic              eop,
    input logic              mod_in,
    input logic              err_in,
    input logic [NPORTS-1:0] wr_strobe,
    input logic              avail,
    input logic              avail_oe,
    input logic              par_err,
    input logic              proto_err
);
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_strobe)); // R4
    AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (|wr_strobe) |-> $past(!wr_en_n)); // R4
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        wr_en_n |-> (!avail_oe && !avail)); // R11
    AST_NULL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_n && addr == 5'h1F) |=> !avail_oe); // R3
    AST_NULL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_n && addr == 5'h1F) |=> ##1 ($past(!wr_en_n) |-> wr_strobe == '0)); // R3
    AST_BOTH_ENDS: assert property (@(posedge clk) disable iff (rst)
        (avail_oe && sop && eop) |=> proto_err); // R7
    AST_STRAY_ERR: assert property (@(posedge clk) disable iff (rst)
        (avail_oe && err_in && !eop) |=> proto_err); // R8
    AST_PARITY: assert property (@(posedge clk) disable iff (rst)
        (avail_oe && (((^data) ^ par_in) != par_odd)) |=> par_err); // R5
    AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (rst)
        (par_err || proto_err) |-> (|wr_strobe)); // R4
endmodule

bind pktbus_tx_port pktbus_tx_port_chk #(
    .AW(AW), .DW(DW), .NPORTS(NPORTS)
) u_bound_chk (
    .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .addr(addr), .data(data),
    .par_in(par_in), .par_odd(par_odd), .sop(sop), .eop(eop),
    .mod_in(mod_in), .err_in(err_in), .wr_strobe(wr_strobe),
    .avail(avail), .avail_oe(avail_oe), .par_err(par_err),
    .proto_err(proto_err)
);

// File: tb/pktbus_tx_port_bench.sv
module pktbus_tx_port_bench;
    localparam int NP = 4;
    localparam int BASE = 4;
    localparam int DEPTH = 15;
    localparam int TH = 10;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en_n = 1'b1;
    logic [4:0] addr = 5'h1F;
    logic [15:0] data = '0;
    logic par_in = 1'b0, par_odd = 1'b0;
    logic sop = 1'b0, eop = 1'b0, mod_in = 1'b0, err_in = 1'b0;
    logic [NP*CW-1:0] fifo_count = '0;
    logic [NP-1:0] wr_strobe;
    logic [15:0] wr_data;
    logic wr_sop, wr_eop, wr_mod, wr_err, avail, avail_oe, par_err, proto_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pktbus_tx_port #(
        .NPORTS(NP), .BASE_ADDR(BASE), .FIFO_DEPTH(DEPTH), .THRESH(TH)
    ) u_pktbus_tx_port (
        .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .addr(addr), .data(data),
        .par_in(par_in), .par_odd(par_odd), .sop(sop), .eop(eop),
        .mod_in(mod_in), .err_in(err_in), .fifo_count(fifo_count),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .wr_sop(wr_sop),
        .wr_eop(wr_eop), .wr_mod(wr_mod), .wr_err(wr_err), .avail(avail),
        .avail_oe(avail_oe), .par_err(par_err), .proto_err(proto_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic select_addr(input logic [4:0] a);
        wr_en_n = 1'b1;
        addr = a;
        #1;
        check("R11 oe idle", {30'd0, avail_oe, avail}, 32'd0);
        @(negedge clk);
    endtask

    task automatic put_word(input logic [4:0] a, input logic [15:0] d, input logic pbad,
                            input logic [3:0] m);
        wr_en_n = 1'b0;
        addr = a;
        data = d;
        {sop, eop, mod_in, err_in} = m;
        par_in = (^d) ^ par_odd ^ pbad;
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_data(input logic [15:0] d, input logic [3:0] m);
        return (m[2] && m[1]) ? {d[15:8], 8'h00} : d;
    endfunction

    function automatic logic exp_viol(input logic [3:0] m);
        return (m[3] & m[2]) | (m[0] & ~m[2]) | (m[1] & ~m[2]);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 strobe reset", {28'd0, wr_strobe}, 32'd0);
        check("R1 flags reset", {30'd0, par_err, proto_err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {26'd0, wr_strobe, avail, avail_oe}, 32'd0);

        // R2 R3 R4: every address, one word each
        for (int a = 0; a < 32; a++) begin
            logic ok;
            logic [15:0] d;
            ok = (a >= BASE) && (a < BASE + NP) && (a != 31);
            d = 16'(a * 16'h0901 + 16'h1234);
            select_addr(5'(a));
            wr_en_n = 1'b0;
            addr = 5'(a);
            data = d;
            {sop, eop, mod_in, err_in} = 4'b0000;
            par_in = ^d;
            #1;
            check("R3 R10 oe per addr", {31'd0, avail_oe}, {31'd0, ok});
            @(negedge clk);
            check("R3 R4 strobe per addr", {28'd0, wr_strobe},
                  ok ? (32'd1 << (a - BASE)) : 32'd0);
            if (ok) check("R4 data", {16'd0, wr_data}, {16'd0, d});
            check("R3 no flags", {30'd0, par_err, proto_err}, 32'd0);
        end

        // R2: address moves during the transfer phase
        select_addr(5'(BASE + 1));
        put_word(5'(BASE + 2), 16'hA5A5, 1'b0, 4'b1000);
        check("R2 held port", {28'd0, wr_strobe}, 32'd2);
        put_word(5'h1F, 16'h5A5A, 1'b0, 4'b0000);
        check("R2 held over null", {28'd0, wr_strobe}, 32'd2);
        put_word(5'd0, 16'h0F0F, 1'b0, 4'b0100);
        check("R2 held to end", {28'd0, wr_strobe}, 32'd2);

        // R5: parity sweep, both senses
        select_addr(5'(BASE));
        for (int po = 0; po < 2; po++) begin
            par_odd = po[0];
            for (int i = 0; i < 64; i++) begin
                logic [15:0] d;
                d = 16'(i * 16'h0421) ^ 16'(i << 9);
                put_word(5'(BASE), d, i[0], 4'b0000);
                check("R5 par_err", {31'd0, par_err}, {31'd0, i[0]});
                check("R5 data kept", {16'd0, wr_data}, {16'd0, d});
            end
        end
        par_odd = 1'b0;

        // R6 R7 R8 R9: all marker combinations, odd ones with bad parity
        select_addr(5'(BASE + 3));
        for (int m = 0; m < 16; m++) begin
            logic [15:0] d;
            d = 16'hC3C3 ^ 16'(m * 16'h1111);
            put_word(5'(BASE + 3), d, m[0], 4'(m));
            check("R7 R8 R9 proto_err", {31'd0, proto_err}, {31'd0, exp_viol(4'(m))});
            check("R5 par_err with markers", {31'd0, par_err}, {31'd0, m[0]});
            check("R6 R9 data", {16'd0, wr_data}, {16'd0, exp_data(d, 4'(m))});
            check("R4 markers", {28'd0, wr_sop, wr_eop, wr_mod, wr_err}, 32'(m));
            check("R4 strobe port3", {28'd0, wr_strobe}, 32'd8);
        end

        // R10 R11: fill threshold per port
        for (int p = 0; p < NP; p++) begin
            fifo_count = '1;
            select_addr(5'(BASE + p));
            wr_en_n = 1'b0;
            for (int c = 0; c <= DEPTH; c++) begin
                fifo_count[p*CW +: CW] = CW'(c);
                #1;
                check("R10 avail", {30'd0, avail_oe, avail}, {30'd0, 1'b1, c < TH});
                @(negedge clk);
            end
        end
        select_addr(5'h1F);
        wr_en_n = 1'b0;
        fifo_count = '0;
        #1;
        check("R3 null no oe", {30'd0, avail_oe, avail}, 32'd0);
        @(negedge clk);
        wr_en_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule